// File: doc/BRIEF.md
# USB PLL Clock Gating Sequencer

This block sits beside a dedicated USB phase-locked loop and decides when the PLL is powered and which of its derived clocks reach the rest of the chip. It produces a USB clock at half the PLL rate, so a PLL near 96 MHz yields the 48 MHz that USB host and device logic need. It also gates an infrared-port clock and a camera clock. The PLL itself is modelled as the free-running `clk_pll` input. Its lock time is a programmable number of `clk_pll` cycles.

A small state machine moves between three states: PLL off, PLL locking, and PLL running. Software can power the PLL down with a disable bit. It can restart the lock wait with a configuration strobe, for example after it reprograms the PLL. Entering STOP or SLEEP powers the PLL down automatically. When the PLL powers up again it always waits out the lock time first, and then releases each derived clock only if that clock's own enable bit is set. The infrared and camera clocks pass through latch-based gates, so they start and stop only with whole high pulses. The USB divider parks low when it is disabled.

Top module: `upll_clk_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycles after reset, `pll_pwr_req` is 1 and the sequencer is in the running state, so each derived clock is delivered as soon as its enable bit is 1.
- R2: While running with `usb_on` = 1, `usb_clk` toggles on every rising edge of `clk_pll`, giving half the PLL frequency. When it is not enabled, it returns to 0 and stays there.
- R3: A one-cycle `cfg_strobe` while running starts a lock wait. All three derived clocks stay low for the lock wait of `lock_cycles` cycles, and each one whose enable bit is 1 is then released again. `pll_pwr_req` stays 1 throughout.
- R4: A `cfg_strobe` that arrives during a lock wait restarts the lock count from zero.
- R5: While `pll_off` = 1, `pll_pwr_req` is 0 and all three derived clocks are held low. Once it is cleared, the PLL is requested again and the clocks return after a full lock wait.
- R6: A 1 on `stop_mode` or `sleep_mode` powers the PLL down (`pll_pwr_req` = 0) on the next rising edge, from either the locking or the running state.
- R7: On leaving STOP or SLEEP, the block passes through a lock wait. After it, only the clocks whose enable bit (`usb_on`, `ir_on`, `cam_on`) is 1 restart.
- R8: `ir_clk` and `cam_clk` are low whenever `clk_pll` is low. They start or stop only at the boundaries of whole `clk_pll` high phases.
- R9: A `lock_cycles` value of 0 behaves as a lock wait of one cycle.
- R10: While running, clearing or setting an enable bit stops or restarts only that clock. The infrared and camera clocks respond in the second high phase after the input edge that samples the new enable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pll | input | 1 | PLL output clock, the clock of the block |
| rst_n | input | 1 | Synchronous active-low reset |
| pll_off | input | 1 | Software PLL power-down bit |
| cfg_strobe | input | 1 | One-cycle pulse after a PLL reconfiguration |
| usb_on | input | 1 | Enable for the USB clock |
| ir_on | input | 1 | Enable for the infrared-port clock |
| cam_on | input | 1 | Enable for the camera clock |
| stop_mode | input | 1 | STOP low-power mode indicator |
| sleep_mode | input | 1 | SLEEP low-power mode indicator |
| lock_cycles | input | LOCK_W | Lock wait length in `clk_pll` cycles (0 counts as 1) |
| pll_pwr_req | output | 1 | Power request to the PLL |
| usb_clk | output | 1 | Gated PLL clock divided by two |
| ir_clk | output | 1 | Latch-gated infrared-port clock |
| cam_clk | output | 1 | Latch-gated camera clock |

## Verification
`pll_pwr_req` follows the state register and is due in the same cycle as the rising edge that samples a control input. `usb_clk` changes one edge after the registered enable changes. `ir_clk` and `cam_clk` follow the enable registered one edge earlier, because the gate latch closes while the clock is high. A reference model in the bench advances once per rising edge. It samples all outputs a quarter period after that edge and keeps the previous enable value to compare against the latch-gated clocks. A second sample in every low phase confirms that those clocks are low and that the divider holds its value.

// File: rtl/upll_pkg.sv
// Shared types for the USB PLL clock sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package upll_pkg;
    // Power sequencing states of the PLL.
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOCK = 2'd1,
        ST_RUN  = 2'd2
    } pll_state_t;

    // Index of each derived clock inside the enable vector.
    localparam int IDX_USB = 0;
    localparam int IDX_IR  = 1;
    localparam int IDX_CAM = 2;
    localparam int NUM_CLK = 3;
endpackage

// File: rtl/upll_lock_fsm.sv
// Power and lock sequencer for the USB PLL.
// Moves between OFF, LOCK and RUN. It counts lock_cycles cycles of clk in LOCK
// before it declares the PLL stable. Power-down (software bit or low-power mode)
// has priority over the configuration strobe, and the strobe has priority over
// the lock count. Assumes lock_cycles is stable while LOCK is active.
module upll_lock_fsm
    import upll_pkg::*;
#(
    parameter int LOCK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pll_off,
    input  logic              low_pwr,
    input  logic              cfg_strobe,
    input  logic [LOCK_W-1:0] lock_cycles,
    output pll_state_t        state_o,
    output logic              pwr_req_o
);
    localparam int CMP_W = LOCK_W + 1;

    pll_state_t        state_q, state_d;
    logic [LOCK_W-1:0] cnt_q, cnt_d;
    logic [CMP_W-1:0]  cnt_next;
    logic              lock_done;
    logic              go_down;

    // Lock completes when the next count reaches the programmed length; 0 acts as 1.
    always_comb begin
        cnt_next  = {1'b0, cnt_q} + CMP_W'(1);
        lock_done = (cnt_next >= {1'b0, lock_cycles});
        go_down   = pll_off | low_pwr;
    end

    // Next-state and lock-counter decision.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_OFF: begin
                if (!go_down) begin
                    state_d = ST_LOCK;
                    cnt_d   = '0;
                end
            end
            ST_LOCK: begin
                if (go_down) begin
                    state_d = ST_OFF;
                end else if (cfg_strobe) begin
                    cnt_d = '0;
                end else if (lock_done) begin
                    state_d = ST_RUN;
                end else begin
                    cnt_d = cnt_next[LOCK_W-1:0];
                end
            end
            ST_RUN: begin
                if (go_down) begin
                    state_d = ST_OFF;
                end else if (cfg_strobe) begin
                    state_d = ST_LOCK;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_OFF;
            end
        endcase
    end

    // State and counter registers; reset leaves the PLL running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state_o   = state_q;
    assign pwr_req_o = (state_q != ST_OFF);

    // R6: a low-power mode shuts the PLL on the next edge.
    a_r6_lowpower_off: assert property (@(posedge clk) disable iff (!rst_n)
        low_pwr |=> (state_q == ST_OFF));

    // R5: the software off bit removes the power request.
    a_r5_soft_off: assert property (@(posedge clk) disable iff (!rst_n)
        pll_off |=> !pwr_req_o);

    // R7: leaving OFF always enters the lock wait first.
    a_r7_wake_via_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |=> (state_q == ST_OFF) || (state_q == ST_LOCK));

    // R4: a strobe during the lock wait restarts the count.
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && cfg_strobe && !pll_off && !low_pwr)
            |=> (state_q == ST_LOCK && cnt_q == '0));
endmodule

// File: rtl/upll_clk_gate.sv
// Latch-based glitch-free clock gate.
// The enable passes the latch only while clk is low, so the output shows only
// whole high phases of clk. Assumes en is driven from logic clocked on clk.
module upll_clk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk_o
);
    logic en_l;

    // Capture the enable during the low phase of the clock.
    always_latch begin
        if (!clk) begin
            en_l = en;
        end
    end

    assign gclk_o = clk & en_l;

    // R8: the gated clock is never high while the source clock is low.
    always_comb begin
        a_r8_low_when_src_low: assert (clk || !gclk_o || $isunknown(gclk_o));
    end
endmodule

// File: rtl/upll_usb_div.sv
// Divide-by-two USB clock generator with a synchronous enable.
// When disabled, the divider goes to 0 at the next edge and stays there, so the
// output never produces a short pulse. Assumes en is registered on clk.
module upll_usb_div (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic usb_clk_o
);
    logic div_q;

    // Toggle while enabled, park low otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= 1'b0;
        end else if (en) begin
            div_q <= ~div_q;
        end else begin
            div_q <= 1'b0;
        end
    end

    assign usb_clk_o = div_q;

    // R2: a disabled divider sits at 0.
    a_r2_parks_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !usb_clk_o);

    // R2: an enabled divider changes level on every edge.
    a_r2_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (usb_clk_o != $past(usb_clk_o)));
endmodule

// File: rtl/upll_clk_seq.sv
// Top of the USB PLL clock sequencer.
// Combines the low-power indicators, runs the lock sequencer, registers the
// per-clock enables (only in RUN), and drives the USB divider and the two
// latch-gated clocks. All logic runs on the PLL output clock clk_pll.
module upll_clk_seq
    import upll_pkg::*;
#(
    parameter int LOCK_W = 16
) (
    input  logic              clk_pll,
    input  logic              rst_n,
    input  logic              pll_off,
    input  logic              cfg_strobe,
    input  logic              usb_on,
    input  logic              ir_on,
    input  logic              cam_on,
    input  logic              stop_mode,
    input  logic              sleep_mode,
    input  logic [LOCK_W-1:0] lock_cycles,
    output logic              pll_pwr_req,
    output logic              usb_clk,
    output logic              ir_clk,
    output logic              cam_clk
);
    localparam int FIRST_LATCH = IDX_IR;

    pll_state_t           state;
    logic                 low_pwr;
    logic [NUM_CLK-1:0]   clk_on;
    logic [NUM_CLK-1:0]   en_q;
    logic [NUM_CLK-1:0]   gclk;

    // Either low-power mode shuts the PLL.
    always_comb begin
        low_pwr              = stop_mode | sleep_mode;
        clk_on[IDX_USB]      = usb_on;
        clk_on[IDX_IR]       = ir_on;
        clk_on[IDX_CAM]      = cam_on;
    end

    upll_lock_fsm #(
        .LOCK_W (LOCK_W)
    ) u_fsm (
        .clk         (clk_pll),
        .rst_n       (rst_n),
        .pll_off     (pll_off),
        .low_pwr     (low_pwr),
        .cfg_strobe  (cfg_strobe),
        .lock_cycles (lock_cycles),
        .state_o     (state),
        .pwr_req_o   (pll_pwr_req)
    );

    // Register the per-clock enables; a clock is allowed only once the PLL runs.
    always_ff @(posedge clk_pll) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= (state == ST_RUN) ? clk_on : '0;
        end
    end

    upll_usb_div u_usb_div (
        .clk       (clk_pll),
        .rst_n     (rst_n),
        .en        (en_q[IDX_USB]),
        .usb_clk_o (gclk[IDX_USB])
    );

    // One latch gate for each directly gated clock.
    generate
        for (genvar g = FIRST_LATCH; g < NUM_CLK; g++) begin : g_gate
            upll_clk_gate u_gate (
                .clk    (clk_pll),
                .en     (en_q[g]),
                .gclk_o (gclk[g])
            );
        end
    endgenerate

    assign usb_clk = gclk[IDX_USB];
    assign ir_clk  = gclk[IDX_IR];
    assign cam_clk = gclk[IDX_CAM];

    // R10: an enable is granted only if the PLL was running at the previous edge.
    a_r10_needs_run: assert property (@(posedge clk_pll) disable iff (!rst_n)
        (|en_q) |-> ($past(state) == ST_RUN));

    // R3: no enable survives one edge into a lock wait.
    a_r3_dark_in_lock: assert property (@(posedge clk_pll) disable iff (!rst_n)
        (state == ST_LOCK) |=> (en_q == '0) || ($past(state) != ST_LOCK));
endmodule

// File: tb/upll_clk_seq_tb.sv
// Reference-model bench for upll_clk_seq.
module upll_clk_seq_tb;
    localparam int T      = 10;
    localparam int LOCK_W = 16;

    logic              clk_pll = 1'b0;
    logic              rst_n = 1'b0;
    logic              pll_off = 1'b0, cfg_strobe = 1'b0;
    logic              usb_on = 1'b1, ir_on = 1'b1, cam_on = 1'b1;
    logic              stop_mode = 1'b0, sleep_mode = 1'b0;
    logic [LOCK_W-1:0] lock_cycles = 16'd4;
    logic              pll_pwr_req, usb_clk, ir_clk, cam_clk;

    int    checks = 0, errors = 0, edges = 0;
    bit    done = 0;
    string tag = "R1";

    // reference model state
    int m_st = 2, m_cnt = 0, m_usb = 0, m_eu = 0, m_ei = 0, m_ec = 0;
    int x_ir = 0, x_cam = 0;

    upll_clk_seq #(.LOCK_W(LOCK_W)) u_dut (
        .clk_pll(clk_pll), .rst_n(rst_n), .pll_off(pll_off), .cfg_strobe(cfg_strobe),
        .usb_on(usb_on), .ir_on(ir_on), .cam_on(cam_on), .stop_mode(stop_mode),
        .sleep_mode(sleep_mode), .lock_cycles(lock_cycles), .pll_pwr_req(pll_pwr_req),
        .usb_clk(usb_clk), .ir_clk(ir_clk), .cam_clk(cam_clk)
    );

    always #(T/2) clk_pll = ~clk_pll;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s at edge %0d: actual %0d expected %0d", req, what, edges, act, exp);
        end
    endtask

    // Advance the model by one rising edge using the inputs it sampled.
    task automatic model_edge();
        int lp, run, lk;
        if (!rst_n) begin
            m_st = 2; m_cnt = 0; m_usb = 0; m_eu = 0; m_ei = 0; m_ec = 0;
            x_ir = 0; x_cam = 0;
            return;
        end
        x_ir  = m_ei;
        x_cam = m_ec;
        m_usb = m_eu ? (1 - m_usb) : 0;
        run   = (m_st == 2);
        m_eu  = run && usb_on;
        m_ei  = run && ir_on;
        m_ec  = run && cam_on;
        lp    = stop_mode || sleep_mode;
        lk    = int'(lock_cycles);
        if (m_st == 0) begin
            if (!pll_off && !lp) begin m_st = 1; m_cnt = 0; end
        end else if (m_st == 1) begin
            if (pll_off || lp) m_st = 0;
            else if (cfg_strobe) m_cnt = 0;
            else if (m_cnt + 1 >= lk) m_st = 2;
            else m_cnt++;
        end else begin
            if (pll_off || lp) m_st = 0;
            else if (cfg_strobe) begin m_st = 1; m_cnt = 0; end
        end
    endtask

    // Compare on every clock: high-phase sample after the edge, then low-phase sample.
    initial begin
        while (!done) begin
            @(posedge clk_pll);
            edges++;
            #(T/4);
            model_edge();
            check(rst_n ? tag : "R1", "pll_pwr_req", int'(pll_pwr_req), int'(m_st != 0));
            if (edges > 2) begin
                check(tag, "usb_clk", int'(usb_clk), m_usb);
                check(tag, "ir_clk", int'(ir_clk), x_ir);
                check(tag, "cam_clk", int'(cam_clk), x_cam);
                #(T/2);
                check("R8", "ir_clk low phase", int'(ir_clk), 0);
                check("R8", "cam_clk low phase", int'(cam_clk), 0);
                check("R8", "usb_clk held in low phase", int'(usb_clk), m_usb);
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_pll);
    endtask

    task automatic pulse_cfg();
        cfg_strobe = 1'b1; step(1); cfg_strobe = 1'b0;
    endtask

    initial begin
        automatic logic [15:0] lfsr = 16'hACE1;
        step(4);
        rst_n = 1'b1;
        tag = "R1"; step(8);
        tag = "R2"; step(8);
        tag = "R10"; ir_on = 1'b0; step(6); ir_on = 1'b1; cam_on = 1'b0; step(6);
        cam_on = 1'b1; step(4);
        tag = "R3"; pulse_cfg(); step(10);
        tag = "R4"; pulse_cfg(); step(2); pulse_cfg(); step(2); pulse_cfg(); step(10);
        tag = "R9"; lock_cycles = '0; pulse_cfg(); step(5);
        lock_cycles = 16'd1; pulse_cfg(); step(5);
        lock_cycles = 16'd6;
        tag = "R5"; pll_off = 1'b1; step(8); pll_off = 1'b0; step(12);
        tag = "R6"; stop_mode = 1'b1; step(6);
        tag = "R7"; cam_on = 1'b0; stop_mode = 1'b0; step(12);
        tag = "R6"; sleep_mode = 1'b1; step(5);
        tag = "R7"; usb_on = 1'b0; cam_on = 1'b1; sleep_mode = 1'b0; step(12);
        tag = "R6"; pulse_cfg(); step(2); stop_mode = 1'b1; step(3); stop_mode = 1'b0; step(10);
        tag = "R5"; lock_cycles = 16'd3;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pll_off    = (lfsr[3:0] == 4'h0);
            stop_mode  = (lfsr[7:4] == 4'h1);
            sleep_mode = (lfsr[7:4] == 4'h2);
            cfg_strobe = (lfsr[11:8] == 4'h3);
            usb_on = lfsr[12]; ir_on = lfsr[13] | lfsr[1]; cam_on = lfsr[14] | lfsr[2];
            step(1);
        end
        pll_off = 1'b0; stop_mode = 1'b0; sleep_mode = 1'b0; cfg_strobe = 1'b0;
        step(12);
        done = 1;
        step(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(T * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule